// File: doc/BRIEF.md
# Serial Receive Line Conditioner with Baud Measurement

This block sits between a device's serial receive pin and the bit sampler of a configurable asynchronous receiver. It selects either the external pin or the local transmit line, synchronizes the selected signal into the system clock domain, and corrects its polarity so the line it hands on always idles high. The sampler also receives a delivery qualifier that says whether it may turn the line into data.

Two self-clearing services run on the conditioned line. The first is a wake detector. Once armed, it reports the first falling edge with a one-cycle interrupt and disarms itself on the rising edge that follows. The second is a baud measurement engine. Once a request is armed, it times the next character, which must be the alternating sync value 0x55. From that timing it produces a divisor for the baud generator, gives a one-cycle completion strobe and clears the request. The measurement is abandoned if its counter saturates.

Top module: `uart_rx_frontend`

## Requirements
- R1: `rx_line` equals the selected input after SYNC_STAGES (default 2) clock edges. It is passed unchanged when `cfg_invert` is 0 and complemented when `cfg_invert` is 1, so an idle line reads 1 in both cases.
- R2: When `cfg_loopback` is 1, `tx_line` is the selected input and `rx_pin` has no effect. When it is 0, `rx_pin` is the selected input.
- R3: While `cfg_enable` is 0, `rx_line` is 1 and `rx_deliver` is 0. No wake interrupt or baud event occurs, `wake_armed` and `abd_pending` are forced to 0, and set pulses on `wake_set` and `abd_set` are ignored.
- R4: While `wake_armed` is 1, a falling edge on `rx_line` produces a `wake_irq` pulse exactly one cycle long, in the cycle after the edge first appears on `rx_line`.
- R5: `wake_set` arms the wake detector. The detector disarms itself one cycle after the next rising edge on `rx_line`, and a later falling edge then raises no interrupt.
- R6: Once `abd_pending` is 1, the next falling edge on `rx_line` starts a measurement. Let T be the number of cycles from that edge to the fifth falling edge. On the fifth edge, `baud_div` becomes max(T>>7,1)-1 when `cfg_hispeed` is 0 and max(T>>5,1)-1 when it is 1. At the same time `baud_done` pulses for one cycle and `abd_pending` clears.
- R7: `rx_deliver` is 0 whenever `abd_pending` is 1, so the sync character is withheld from the sampler. Otherwise it follows `cfg_enable`.
- R8: If the measurement counter reaches 2^CNT_W-1 (default 65535) before the fifth falling edge, then `baud_abort` pulses for one cycle, `abd_pending` clears and `baud_div` keeps its previous value.
- R9: An `abd_set` pulse that arrives while a measurement is running is ignored. `abd_pending` clears at completion as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Block enable |
| cfg_loopback | input | 1 | Use the transmit line instead of the pin |
| cfg_invert | input | 1 | Pin idles low; complement before use |
| cfg_hispeed | input | 1 | 4x oversampling divisor instead of 16x |
| wake_set | input | 1 | Pulse that arms the wake detector |
| abd_set | input | 1 | Pulse that arms a baud measurement |
| rx_pin | input | 1 | External serial input |
| tx_line | input | 1 | Local transmit line, used for loopback |
| rx_line | output | 1 | Conditioned line, idle high |
| rx_deliver | output | 1 | Sampler may decode data |
| wake_armed | output | 1 | Wake detector armed |
| wake_irq | output | 1 | One-cycle wake interrupt |
| abd_pending | output | 1 | Baud measurement requested or running |
| baud_div | output | DIV_W | Measured baud divisor |
| baud_done | output | 1 | One-cycle strobe when a new divisor is produced |
| baud_abort | output | 1 | One-cycle strobe when a measurement is abandoned |

## Verification
An input change reaches `rx_line` after SYNC_STAGES edges. The wake interrupt, the wake disarm, the baud divisor, the completion or abort strobe and the clearing of the request all appear one cycle after the edge on `rx_line` that causes them. The bench's behavioural model applies the same delays: a queue holds the synchronizer delay, and integer state is updated once per rising edge. Every output is compared at the falling edge of each clock, so each result is checked in the exact cycle it is due. Directed checks then confirm the specific divisor values and confirm that a saturated measurement leaves the divisor unchanged.

// File: rtl/uart_rxfe_pkg.sv
package uart_rxfe_pkg;

   typedef enum logic [0:0] {
      ABD_IDLE = 1'b0,
      ABD_MEAS = 1'b1
   } abd_state_t;

   // A 0x55 sync character shows five falling edges spread over eight bit times
   localparam int unsigned SYNC_FALLS     = 5;
   localparam int unsigned SPAN_BITS_LOG2 = 3;
   localparam int unsigned OVS_SLOW_LOG2  = 4;
   localparam int unsigned OVS_FAST_LOG2  = 2;

   function automatic logic [31:0] divisor_from_span(input logic [31:0] span,
                                                     input logic        fast);
      logic [31:0] per_tick;
      per_tick = fast ? (span >> (SPAN_BITS_LOG2 + OVS_FAST_LOG2))
                      : (span >> (SPAN_BITS_LOG2 + OVS_SLOW_LOG2));
      return (per_tick == 32'd0) ? 32'd0 : per_tick - 32'd1;
   endfunction

endpackage

// File: rtl/uart_rxfe_cond.sv
module uart_rxfe_cond #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic loopback,
   input  logic invert,
   input  logic rx_pin,
   input  logic tx_line,
   output logic line,
   output logic fall,
   output logic rise
);

   logic                   raw;
   logic [SYNC_STAGES-1:0] chain;
   logic                   line_q;

   assign raw = loopback ? tx_line : rx_pin;

   // The stage at the top of the chain holds the oldest sample
   generate
      if (SYNC_STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[0], raw};
         end
      end else begin : g_deep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], raw};
         end
      end
   endgenerate

   assign line = en ? (chain[SYNC_STAGES-1] ^ invert) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line;
   end

   assign fall = line_q & ~line;
   assign rise = ~line_q & line;

endmodule

// File: rtl/uart_rxfe_wake.sv
module uart_rxfe_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic arm,
   input  logic fall,
   input  logic rise,
   output logic armed,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= en & armed & fall;
         if (!en)                armed <= 1'b0;
         else if (arm)           armed <= 1'b1;
         else if (armed && rise) armed <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rxfe_abd.sv
module uart_rxfe_abd
   import uart_rxfe_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DIV_W      = 16,
   parameter bit          HS_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             req_set,
   input  logic             hispeed,
   input  logic             fall,
   output logic             req,
   output logic [DIV_W-1:0] divisor,
   output logic             done,
   output logic             abort
);

   localparam int unsigned FALL_W    = $clog2(SYNC_FALLS);
   localparam int unsigned LAST_FALL = SYNC_FALLS - 2;

   abd_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [FALL_W-1:0] falls;
   logic              fast;
   logic              last_edge;
   logic              saturated;

   generate
      if (HS_SUPPORT) begin : g_hs
         assign fast = hispeed;
      end else begin : g_no_hs
         logic unused_hs;
         assign unused_hs = hispeed;
         assign fast      = 1'b0;
      end
   endgenerate

   assign last_edge = fall && (falls == FALL_W'(LAST_FALL));
   assign saturated = (cnt == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ABD_IDLE;
         req     <= 1'b0;
         cnt     <= '0;
         falls   <= '0;
         divisor <= '0;
         done    <= 1'b0;
         abort   <= 1'b0;
      end else begin
         done  <= 1'b0;
         abort <= 1'b0;
         if (!en) begin
            state <= ABD_IDLE;
            req   <= 1'b0;
         end else begin
            case (state)
               ABD_IDLE: begin
                  if (req && fall) begin
                     state <= ABD_MEAS;
                     cnt   <= CNT_W'(1);
                     falls <= '0;
                  end
               end
               ABD_MEAS: begin
                  if (last_edge) begin
                     divisor <= DIV_W'(divisor_from_span(32'(cnt), fast));
                     done    <= 1'b1;
                     req     <= 1'b0;
                     state   <= ABD_IDLE;
                  end else if (saturated) begin
                     abort <= 1'b1;
                     req   <= 1'b0;
                     state <= ABD_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                     if (fall) falls <= falls + FALL_W'(1);
                  end
               end
               default: state <= ABD_IDLE;
            endcase
            if (req_set && state == ABD_IDLE) req <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_rx_frontend.sv
module uart_rx_frontend #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DIV_W       = 16,
   parameter bit          HS_SUPPORT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_enable,
   input  logic             cfg_loopback,
   input  logic             cfg_invert,
   input  logic             cfg_hispeed,
   input  logic             wake_set,
   input  logic             abd_set,
   input  logic             rx_pin,
   input  logic             tx_line,
   output logic             rx_line,
   output logic             rx_deliver,
   output logic             wake_armed,
   output logic             wake_irq,
   output logic             abd_pending,
   output logic [DIV_W-1:0] baud_div,
   output logic             baud_done,
   output logic             baud_abort
);

   generate
      if (SYNC_STAGES < 2)         begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
      if (CNT_W < 8 || CNT_W > 31) begin : g_bad_cnt   $error("CNT_W must lie in 8..31");        end
      if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div   $error("DIV_W must lie in 1..32");        end
   endgenerate

   logic line_fall;
   logic line_rise;

   uart_rxfe_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_enable),
      .loopback (cfg_loopback),
      .invert   (cfg_invert),
      .rx_pin   (rx_pin),
      .tx_line  (tx_line),
      .line     (rx_line),
      .fall     (line_fall),
      .rise     (line_rise)
   );

   uart_rxfe_wake u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cfg_enable),
      .arm   (wake_set),
      .fall  (line_fall),
      .rise  (line_rise),
      .armed (wake_armed),
      .irq   (wake_irq)
   );

   uart_rxfe_abd #(.CNT_W(CNT_W), .DIV_W(DIV_W), .HS_SUPPORT(HS_SUPPORT)) u_abd (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg_enable),
      .req_set (abd_set),
      .hispeed (cfg_hispeed),
      .fall    (line_fall),
      .req     (abd_pending),
      .divisor (baud_div),
      .done    (baud_done),
      .abort   (baud_abort)
   );

   assign rx_deliver = cfg_enable & ~abd_pending;

endmodule

// File: rtl/uart_rx_frontend_chk.sv
module uart_rx_frontend_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_enable,
   input logic             rx_line,
   input logic             rx_deliver,
   input logic             wake_armed,
   input logic             wake_irq,
   input logic             abd_pending,
   input logic [DIV_W-1:0] baud_div,
   input logic             baud_done,
   input logic             baud_abort
);

   a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> !wake_irq && !baud_done && !baud_abort);

   a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq);

   a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> $past(wake_armed) && !$past(rx_line));

   a_r6_done_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
      baud_done |-> !abd_pending);

   a_r6_div_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_done |-> $stable(baud_div));

   a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({baud_done, baud_abort}));

   a_r7_withhold: assert property (@(posedge clk) disable iff (!rst_n)
      abd_pending |-> !rx_deliver);

   a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      baud_abort |-> !abd_pending && $stable(baud_div));

endmodule

bind uart_rx_frontend uart_rx_frontend_chk #(.DIV_W(DIV_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_enable  (cfg_enable),
   .rx_line     (rx_line),
   .rx_deliver  (rx_deliver),
   .wake_armed  (wake_armed),
   .wake_irq    (wake_irq),
   .abd_pending (abd_pending),
   .baud_div    (baud_div),
   .baud_done   (baud_done),
   .baud_abort  (baud_abort)
);

// File: tb/uart_rx_frontend_tb.sv
module uart_rx_frontend_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int CW         = 16;
   localparam int DW         = 16;
   localparam int CNT_MAX    = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0, cfg_loopback = 1'b0, cfg_invert = 1'b0, cfg_hispeed = 1'b0;
   logic wake_set = 1'b0, abd_set = 1'b0;
   logic rx_pin = 1'b1, tx_line = 1'b1;
   logic rx_line, rx_deliver, wake_armed, wake_irq, abd_pending, baud_done, baud_abort;
   logic [DW-1:0] baud_div;

   int n_cmp = 0;
   int n_bad = 0;
   int irq_seen = 0, done_seen = 0, abort_seen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_frontend #(.SYNC_STAGES(SYNC), .CNT_W(CW), .DIV_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback),
      .cfg_invert(cfg_invert), .cfg_hispeed(cfg_hispeed), .wake_set(wake_set),
      .abd_set(abd_set), .rx_pin(rx_pin), .tx_line(tx_line), .rx_line(rx_line),
      .rx_deliver(rx_deliver), .wake_armed(wake_armed), .wake_irq(wake_irq),
      .abd_pending(abd_pending), .baud_div(baud_div), .baud_done(baud_done),
      .baud_abort(baud_abort)
   );

   // ---------------- behavioural reference model ----------------
   bit m_q[$];
   bit m_prev, m_wake, m_irq, m_req, m_meas, m_done, m_abort;
   int m_cnt, m_falls, m_div;

   function automatic bit model_line();
      return cfg_enable ? (m_q[0] ^ cfg_invert) : 1'b1;
   endfunction

   task automatic model_reset();
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back(1'b1);
      m_prev = 1; m_wake = 0; m_irq = 0; m_req = 0; m_meas = 0;
      m_done = 0; m_abort = 0; m_cnt = 0; m_falls = 0; m_div = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit ln, fl, rs, was_meas;
         int per;
         ln = model_line();
         fl = m_prev && !ln;
         rs = !m_prev && ln;
         void'(m_q.pop_front());
         m_q.push_back(cfg_loopback ? tx_line : rx_pin);
         m_prev = ln;
         m_irq = cfg_enable && m_wake && fl;
         if (!cfg_enable) m_wake = 0;
         else if (wake_set) m_wake = 1;
         else if (m_wake && rs) m_wake = 0;
         m_done = 0; m_abort = 0;
         was_meas = m_meas;
         if (!cfg_enable) begin
            m_req = 0; m_meas = 0;
         end else begin
            if (m_meas) begin
               if (fl && m_falls == 3) begin
                  per = cfg_hispeed ? (m_cnt / 32) : (m_cnt / 128);
                  m_div = (per == 0) ? 0 : per - 1;
                  m_done = 1; m_req = 0; m_meas = 0;
               end else if (m_cnt == CNT_MAX) begin
                  m_abort = 1; m_req = 0; m_meas = 0;
               end else begin
                  m_cnt++;
                  if (fl) m_falls++;
               end
            end else if (m_req && fl) begin
               m_meas = 1; m_cnt = 1; m_falls = 0;
            end
            if (abd_set && !was_meas) m_req = 1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every cycle away from the active edge
   always @(negedge clk) begin
      chk("R1 R2 R3 rx_line", rx_line, model_line());
      chk("R3 R7 rx_deliver", rx_deliver, cfg_enable && !m_req);
      chk("R5 wake_armed", wake_armed, m_wake);
      chk("R4 wake_irq", wake_irq, m_irq);
      chk("R6 R9 abd_pending", abd_pending, m_req);
      chk("R6 baud_div", baud_div, m_div);
      chk("R6 baud_done", baud_done, m_done);
      chk("R8 baud_abort", baud_abort, m_abort);
      if (wake_irq) irq_seen++;
      if (baud_done) done_seen++;
      if (baud_abort) abort_seen++;
   end

   // ---------------- stimulus ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic send_byte(input logic [7:0] v, input int bt, input bit via_tx);
      logic [9:0] frame;
      frame = {1'b1, v, 1'b0};
      for (int i = 0; i < 10; i++) begin
         if (via_tx) tx_line = frame[i]; else rx_pin = frame[i];
         tick(bt);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk("R3 reset rx_line idle", rx_line, 1);
      chk("R3 reset divisor", baud_div, 0);

      // R3: disabled block ignores arming pulses and pin activity
      wake_set = 1; abd_set = 1; tick(1); wake_set = 0; abd_set = 0;
      rx_pin = 0; tick(5); rx_pin = 1; tick(5);
      chk("R3 wake not armed while disabled", wake_armed, 0);
      chk("R3 request not armed while disabled", abd_pending, 0);
      chk("R3 no irq while disabled", irq_seen, 0);

      // R1: straight polarity
      cfg_enable = 1; tick(4);
      chk("R7 deliver when idle", rx_deliver, 1);
      send_byte(8'hA3, 3, 0);
      rx_pin = 0; tick(1); rx_pin = 1; tick(1);
      chk("R1 line after narrow pulse", rx_line, 0);
      tick(4);

      // R1: inverted polarity, idle low pin
      cfg_enable = 0; cfg_invert = 1; rx_pin = 0; tick(4);
      cfg_enable = 1; tick(2);
      chk("R1 inverted idle reads high", rx_line, 1);
      rx_pin = 1; tick(2);
      chk("R1 inverted active reads low", rx_line, 0);
      rx_pin = 0; tick(4);
      cfg_enable = 0; cfg_invert = 0; rx_pin = 1; tick(4);
      cfg_enable = 1; tick(3);

      // R2: loopback takes tx_line, pin is ignored
      cfg_loopback = 1; rx_pin = 0; tick(4);
      chk("R2 pin ignored in loopback", rx_line, 1);
      send_byte(8'h3C, 4, 1);
      cfg_loopback = 0; rx_pin = 1; tick(4);

      // R4 R5: wake on falling edge, self disarm on rise
      wake_set = 1; tick(1); wake_set = 0; tick(2);
      rx_pin = 0; tick(6);
      chk("R4 one irq on falling edge", irq_seen, 1);
      chk("R5 still armed while low", wake_armed, 1);
      rx_pin = 1; tick(4);
      chk("R5 disarmed after rise", wake_armed, 0);
      rx_pin = 0; tick(4); rx_pin = 1; tick(4);
      chk("R5 no irq once disarmed", irq_seen, 1);

      // R6 R7: normal speed measurement, 64 cycles per bit -> span 512
      abd_set = 1; tick(1); abd_set = 0; tick(1);
      chk("R7 withheld while pending", rx_deliver, 0);
      send_byte(8'h55, 64, 0);
      tick(10);
      chk("R6 divisor 16x", baud_div, 3);
      chk("R6 one done strobe", done_seen, 1);
      chk("R6 request cleared", abd_pending, 0);

      // R6 R9: fast mode, 20 cycles per bit -> span 160, rearm during measurement
      cfg_hispeed = 1;
      abd_set = 1; tick(1); abd_set = 0; tick(2);
      fork
         send_byte(8'h55, 20, 0);
         begin tick(50); abd_set = 1; tick(1); abd_set = 0; end
      join
      tick(10);
      chk("R6 divisor 4x", baud_div, 4);
      chk("R9 rearm during measurement ignored", abd_pending, 0);
      chk("R6 second done strobe", done_seen, 2);

      // R8: counter saturation aborts and keeps the divisor
      abd_set = 1; tick(1); abd_set = 0; tick(2);
      rx_pin = 0;
      tick(CNT_MAX + 20);
      rx_pin = 1; tick(5);
      chk("R8 one abort strobe", abort_seen, 1);
      chk("R8 divisor kept", baud_div, 4);
      chk("R8 request cleared", abd_pending, 0);
      chk("R8 no done on abort", done_seen, 2);

      finish_run();
   end

endmodule